// File: doc/BRIEF.md
# Multi-Mode Programmable Interval Counter

This block is one down-counting timer channel. A register front end hands it an initial count, a mode number and a binary/decimal format flag. The channel then counts pulses of a counting enable (`tick`) and shapes a single output waveform according to the selected mode. The six modes are:

- a terminal-count flag;
- a gate-started one-shot;
- a divide-by-N rate generator;
- a square wave;
- a write-started strobe;
- a gate-started strobe.

A gate input either pauses counting or, in the two gate-started modes, fires and re-fires the count on its rising edge.

The live count, the output level and a flag telling that a written count has not yet reached the counting element are exposed to the front end. Bus decoding, command handling and byte sequencing are outside this block.

Top module: `interval_counter_ch`

## Requirements
- R1: After reset `out` is 1, `null_cnt` is 0, `count` is 0x0000, and the channel does not count until a count is written.
- R2: A `wr_load` pulse sets `null_cnt` and the initial `out` level (0 for mode 0, 1 for every other mode) at the next clock edge. In modes 0, 2, 3 and 4 the value is copied into `count` on the first clock with `tick`=1 after the write, and `null_cnt` clears on that same clock.
- R3: Mode 0: `count` drops by one per tick. `out` rises on the tick that brings `count` to 0. It stays 1 while the count wraps, until the next write.
- R4: In modes 0, 2, 3 and 4, `gate`=0 holds `count` and `out` unchanged.
- R5: Mode 1: a rising edge of `gate` arms the channel. The next tick loads the count and drives `out` to 0. `out` returns to 1 when `count` reaches 0. A later rising edge reloads the count and drives `out` low again. The `gate` level does not pause counting.
- R6: Mode 2 (N>=2): `count` runs N down to 1. `out` is 0 only while `count` is 1. The following tick reloads N and restores `out`=1, so the period is N ticks.
- R7: Mode 3 (N>=2): `count` runs N down to 1 and reloads. `out` is 1 while twice the count exceeds N, otherwise 0. This gives ceil(N/2) ticks high and floor(N/2) ticks low.
- R8: Mode 4: `out` is 1, except for exactly one tick when `count` first reaches 0. Counting continues and wraps.
- R9: Mode 5: it is started and restarted by a rising edge of `gate` as in R5. `out` stays 1 except for one tick low when `count` first reaches 0.
- R10: With `bcd`=1, `count` holds four decimal digits (one per nibble, least significant in bits 3:0). It decrements in decimal, and 0x0000 wraps to 0x9999. With `bcd`=0 it decrements in binary, and 0x0000 wraps to 0xFFFF.
- R11: An initial count of 0 stands for the full range: 65536 ticks in binary, 10000 ticks in decimal.
- R12: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R13: In modes 1 and 5, `null_cnt` stays 1 after a write until a gate edge has caused the count transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counting clock enable, one count step per high cycle |
| gate | input | 1 | Gate: pause control or start trigger, depending on mode |
| wr_load | input | 1 | One-cycle strobe: a new count, mode and format are written |
| load_val | input | 16 | Initial count (binary, or four BCD digits) |
| mode | input | 3 | Operating mode 0 to 7 (6 and 7 alias 2 and 3) |
| bcd | input | 1 | 1 selects decimal counting |
| out | output | 1 | Channel output waveform |
| count | output | 16 | Live count |
| null_cnt | output | 1 | Written count not yet transferred to the counter |

## Verification
Every result is a register, so it is due at the first clock edge after its cause. The `null_cnt` and initial `out` level follow a write by one edge. The count transfer in write-started modes lands on the next edge with `tick`=1. In gate-started modes a gate edge is captured at one edge and loaded at the next tick, so the transfer is two edges after the gate rises. After that, `count` and `out` move once per tick. The bench drives and samples only on falling clock edges and holds `tick` high, so each expected value falls at a whole number of cycles after the driving edge. The full-range decimal case is stepped through all ten thousand counts, and the low pulse is checked at its exact cycle.

// File: rtl/interval_counter_ch.sv
module interval_counter_ch #(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  gate,
  input  logic                  wr_load,
  input  logic [4*DIGITS-1:0]   load_val,
  input  logic [2:0]            mode,
  input  logic                  bcd,
  output logic                  out,
  output logic [4*DIGITS-1:0]   count,
  output logic                  null_cnt
);
  localparam int W  = 4 * DIGITS;
  localparam int VW = W + 2;

  logic [W-1:0] cnt, init, nc;
  logic [2:0]   md;
  logic         bcd_r, running, ld_pend, trig, fired, gate_q;

  function automatic logic [W-1:0] dec_cnt(input logic [W-1:0] c, input logic b);
    logic [W-1:0] r;
    logic brw;
    r = c - 1'b1;
    if (b) begin
      r = c;
      brw = 1'b1;
      for (int i = 0; i < DIGITS; i++) begin
        if (brw) begin
          if (c[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
          else begin
            r[4*i +: 4] = c[4*i +: 4] - 4'd1;
            brw = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] mag(input logic [W-1:0] c, input logic b);
    logic [VW-1:0] v;
    v = '0;
    if (c == '0) begin
      if (b) begin
        v = VW'(1);
        for (int i = 0; i < DIGITS; i++) v = v * VW'(10);
      end else v = {2'b01, {W{1'b0}}};
    end else if (!b) v = {2'b00, c};
    else
      for (int i = DIGITS - 1; i >= 0; i--) v = v * VW'(10) + VW'(c[4*i +: 4]);
    return v;
  endfunction

  wire [2:0] mode_eff = (mode[2:1] == 2'b11) ? {1'b0, mode[1:0]} : mode;
  wire       hw_md    = (md == 3'd1) || (md == 3'd5);
  wire       reload_md = (md == 3'd2) || (md == 3'd3);

  assign nc       = (reload_md && cnt == W'(1)) ? init : dec_cnt(cnt, bcd_r);
  assign count    = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; init <= '0; md <= '0; bcd_r <= 1'b0;
      null_cnt <= 1'b0; out <= 1'b1; running <= 1'b0;
      ld_pend <= 1'b0; trig <= 1'b0; fired <= 1'b0; gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (wr_load) begin
        init     <= load_val;
        md       <= mode_eff;
        bcd_r    <= bcd;
        null_cnt <= 1'b1;
        out      <= (mode_eff != 3'd0);
        running  <= 1'b0;
        ld_pend  <= !((mode_eff == 3'd1) || (mode_eff == 3'd5));
        trig     <= 1'b0;
        fired    <= 1'b0;
      end else begin
        if (hw_md && gate && !gate_q) trig <= 1'b1;
        if (tick) begin
          if (ld_pend || trig) begin
            cnt      <= init;
            null_cnt <= 1'b0;
            ld_pend  <= 1'b0;
            trig     <= 1'b0;
            running  <= 1'b1;
            fired    <= 1'b0;
            out      <= (md != 3'd0) && (md != 3'd1);
          end else if (running && (hw_md || gate)) begin
            cnt <= nc;
            case (md)
              3'd0, 3'd1: out <= out | (nc == '0);
              3'd2:       out <= (nc != W'(1));
              3'd3:       out <= ({mag(nc, bcd_r), 1'b0} > {1'b0, mag(init, bcd_r)});
              default: begin
                if (nc == '0 && !fired) begin
                  out   <= 1'b0;
                  fired <= 1'b1;
                end else out <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  assert_null_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> null_cnt);
  assert_null_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ld_pend && !wr_load) |=> !null_cnt);
  assert_mode0_out_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (md == 3'd0 && out && !wr_load) |=> out);
  assert_gate_pause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (md == 3'd0 && running && !gate && !ld_pend && !wr_load) |=> $stable(cnt));
  assert_rate_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (md == 3'd2 && running && !out && tick && gate && !wr_load) |=> (cnt == init && out));
  assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (md == 3'd4 && !out && tick && gate && !wr_load) |=> out);
endmodule

// File: tb/tb_interval_counter_ch.sv
`timescale 1ns/1ps
module tb_interval_counter_ch;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, gate = 1'b1, wr_load = 1'b0, bcd = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode = '0;
  logic out, null_cnt;
  logic [15:0] count;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  interval_counter_ch dut (.clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
    .wr_load(wr_load), .load_val(load_val), .mode(mode), .bcd(bcd),
    .out(out), .count(count), .null_cnt(null_cnt));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [2:0] m, input logic b, input logic [15:0] v);
    mode = m; bcd = b; load_val = v; wr_load = 1'b1;
    @(negedge clk);
    wr_load = 1'b0;
  endtask

  task automatic t_reset;
    step(3); rst_n = 1'b1; step(2);
    chk("R1 out", out, 1); chk("R1 null", null_cnt, 0); chk("R1 count", count, 0);
  endtask

  task automatic t_mode0;
    gate = 1'b1;
    write(3'd0, 1'b0, 16'd3);
    chk("R2 null set", null_cnt, 1); chk("R2 out init m0", out, 0);
    step(1); chk("R2 transfer", count, 3); chk("R2 null clr", null_cnt, 0);
    step(2); chk("R3 count1", count, 1); chk("R3 out low", out, 0);
    step(1); chk("R3 out high", out, 1); chk("R3 zero", count, 0);
    step(1); chk("R3 wrap", count, 16'hFFFF); chk("R3 stays", out, 1);
  endtask

  task automatic t_pause;
    gate = 1'b1;
    write(3'd0, 1'b0, 16'd5);
    step(1); chk("R4 loaded", count, 5);
    gate = 1'b0; step(3);
    chk("R4 held", count, 5); chk("R4 out held", out, 0);
    gate = 1'b1; step(1); chk("R4 resume", count, 4);
  endtask

  task automatic t_mode1;
    gate = 1'b0;
    write(3'd1, 1'b0, 16'd3);
    chk("R2 out init m1", out, 1);
    step(2); chk("R13 null waits", null_cnt, 1);
    gate = 1'b1; step(1); chk("R13 still armed", null_cnt, 1);
    step(1); chk("R5 load", count, 3); chk("R5 out low", out, 0); chk("R13 null clr", null_cnt, 0);
    gate = 1'b0; step(2); chk("R5 count1", count, 1); chk("R5 still low", out, 0);
    step(1); chk("R5 out high", out, 1);
    step(1); gate = 1'b1; step(1); step(1);
    chk("R5 retrigger count", count, 3); chk("R5 retrigger out", out, 0);
  endtask

  task automatic t_mode2(input logic [2:0] m, input string tag);
    gate = 1'b1;
    write(m, 1'b0, 16'd3);
    step(1); chk({tag, " c3"}, out, 1);
    step(1); chk({tag, " c2"}, out, 1);
    step(1); chk({tag, " c1 low"}, out, 0); chk({tag, " cnt1"}, count, 1);
    step(1); chk({tag, " reload"}, count, 3); chk({tag, " high"}, out, 1);
    step(2); chk({tag, " 2nd low"}, out, 0);
  endtask

  task automatic t_mode3(input logic [2:0] m, input logic [15:0] n, input string tag);
    int hi = 0, lo = 0;
    gate = 1'b1;
    write(m, 1'b0, n);
    for (int i = 0; i < 2 * n; i++) begin
      step(1);
      if (out) hi++; else lo++;
      if (i == 0) chk({tag, " starts high"}, out, 1);
    end
    chk({tag, " high ticks"}, hi, n + (n % 2));
    chk({tag, " low ticks"}, lo, n - (n % 2));
  endtask

  task automatic t_mode4;
    gate = 1'b1;
    write(3'd4, 1'b0, 16'd2);
    chk("R8 init high", out, 1);
    step(2); chk("R8 c1 high", out, 1);
    step(1); chk("R8 pulse", out, 0); chk("R8 zero", count, 0);
    step(1); chk("R8 back high", out, 1); chk("R8 wrap", count, 16'hFFFF);
  endtask

  task automatic t_mode5;
    gate = 1'b0;
    write(3'd5, 1'b0, 16'd2);
    step(1); gate = 1'b1; step(2);
    chk("R9 load", count, 2); chk("R9 high", out, 1);
    step(1); chk("R9 c1 high", out, 1);
    step(1); chk("R9 pulse", out, 0);
    step(1); chk("R9 back high", out, 1);
    gate = 1'b0; step(1); gate = 1'b1; step(2);
    chk("R9 retrigger", count, 2);
  endtask

  task automatic t_bcd;
    gate = 1'b1;
    write(3'd0, 1'b1, 16'h0010);
    step(1); chk("R10 load", count, 16'h0010);
    step(1); chk("R10 digit borrow", count, 16'h0009);
    step(1); chk("R10 dec", count, 16'h0008);
    write(3'd4, 1'b0, 16'h0000);
    step(1); chk("R11 bin zero load", count, 0);
    step(1); chk("R11 bin wrap", count, 16'hFFFF);
  endtask

  task automatic t_full_bcd;
    gate = 1'b1;
    write(3'd2, 1'b1, 16'h0000);
    step(1); chk("R11 bcd zero load", count, 0);
    step(1); chk("R10 bcd wrap", count, 16'h9999);
    step(9997); chk("R11 before end", count, 16'h0002); chk("R11 high", out, 1);
    step(1); chk("R11 pulse at 10000", out, 0);
    step(1); chk("R11 reload", count, 0); chk("R11 high again", out, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_mode0();
    t_pause();
    t_mode1();
    t_mode2(3'd2, "R6");
    t_mode2(3'd6, "R12 m6");
    t_mode3(3'd3, 16'd5, "R7 odd");
    t_mode3(3'd3, 16'd4, "R7 even");
    t_mode3(3'd7, 16'd5, "R12 m7");
    t_mode4();
    t_mode5();
    t_bcd();
    t_full_bcd();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule